// File: doc/BRIEF.md
# Hidden timing-register window for an ATA host port

This block sits between a simple synchronous register port and the task-file interface of a legacy ATA host channel. While the window is locked, every access to the eight command-block offsets is forwarded to the task file unchanged, and read data comes back from the task file. A short stateful access sequence on those same offsets opens a hidden control window. While the window is open, the offsets no longer reach the task file. Instead they address a small bank of drive-timing registers. A dedicated close code shuts the window again and restores normal decoding.

Inside the window the block holds a staged read-cycle timing value and a staged write-cycle timing value for each of two drives. A field in a miscellaneous register picks which drive's pair the timing offsets address. The upper bits of that register carry an address-setup value. A commit code written to the control register copies all staged values to the outputs that feed a downstream strobe generator. Those outputs never move at any other time. A strap register reports a static board strap, and its bit 0 gives the bus clock rate.

Top module: `ata_cfg_window`

## Requirements
- R1: While the window is locked, every access is forwarded: tf_valid equals bus_valid, and tf_write, tf_word, tf_addr and tf_wdata follow the bus. Read data is tf_rdata.
- R2: The window opens when three accesses come in order: a 16-bit read (bus_word=1) of offset 1, another 16-bit read of offset 1, and then an 8-bit write (bus_word=0) of low byte 0x03 to offset 2. The opening write is still forwarded. From the next access on, tf_valid stays 0.
- R3: While the window is locked, any access that breaks the sequence sends it back to the start. Such an access may use a different offset, size, direction or value. The opening write then has no effect, and the next access is still forwarded. A third 16-bit read of offset 1 keeps the two-reads condition.
- R4: While the window is open, a write of low byte 0x83 to offset 2 closes it. That write is not forwarded, and the next access is forwarded again.
- R5: While the window is open, offset 0 holds the read timing and offset 1 holds the write timing of the drive selected by miscellaneous bit 0. Writes take the low byte. Reads return the byte zero-extended. Offsets 2, 4 and 7 read 0.
- R6: The miscellaneous register at offset 6 reads back as written. Bit 0 selects the drive, and bits 7:1 are the address-setup value.
- R7: A write of low byte 0x85 to offset 3 copies the staged values to the outputs. tim_rd_o and tim_wr_o take drive 0 in bits 7:0 and drive 1 in bits 15:8. setup_o takes miscellaneous bits 7:1. The outputs do not change before that write.
- R8: Offset 5 reads strap_in, where bit 0=0 means a 33 MHz bus clock and 1 means 25 MHz. Writes to offset 5 are ignored.
- R9: After reset the window is locked, and every staged and committed timing value is 0xFF. setup_o is 0, and the miscellaneous register reads 0.
- R10: A write to offset 3 of any value other than 0x85 leaves the outputs unchanged. Offset 3 reads back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access strobe, one access per cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| bus_addr | input | 3 | Command-block offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| strap_in | input | 8 | Static board strap, bit 0 = clock rate |
| tf_valid | output | 1 | Forwarded access strobe |
| tf_write | output | 1 | Forwarded direction |
| tf_word | output | 1 | Forwarded size |
| tf_addr | output | 3 | Forwarded offset |
| tf_wdata | output | 16 | Forwarded write data |
| tf_rdata | input | 16 | Task-file read data |
| tim_rd_o | output | 16 | Committed read timing, drive 1 in the high byte |
| tim_wr_o | output | 16 | Committed write timing, drive 1 in the high byte |
| setup_o | output | 7 | Committed address-setup value |

## Verification
Two functions meet in a single cycle at each edge of the window. One is the forwarding of the current access, and the other is the change of lock state that the same access causes. The opening write must still reach the task file even though the window is open in the very next cycle. The closing write must be withheld even though the next access goes through. The bench runs each sequence back to back and samples tf_valid on the key access and on the one after it. It also runs broken sequences and judges them by whether the following access is still forwarded.

// File: rtl/ata_cfg_pkg.sv
package ata_cfg_pkg;

    localparam int OFF_W = 3;
    localparam int KEY_W = 8;

    localparam logic [OFF_W-1:0] OFF_RDTIM = 3'd0;
    localparam logic [OFF_W-1:0] OFF_WRTIM = 3'd1;
    localparam logic [OFF_W-1:0] OFF_PROBE = 3'd1;
    localparam logic [OFF_W-1:0] OFF_KEY   = 3'd2;
    localparam logic [OFF_W-1:0] OFF_CTRL  = 3'd3;
    localparam logic [OFF_W-1:0] OFF_STRAP = 3'd5;
    localparam logic [OFF_W-1:0] OFF_MISC  = 3'd6;

    localparam logic [KEY_W-1:0] KEY_OPEN   = 8'h03;
    localparam logic [KEY_W-1:0] KEY_CLOSE  = 8'h83;
    localparam logic [KEY_W-1:0] KEY_COMMIT = 8'h85;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_ONE  = 2'd1,
        SEQ_TWO  = 2'd2
    } seq_e;

    typedef struct packed {
        logic             valid;
        logic             write;
        logic             word;
        logic [OFF_W-1:0] addr;
        logic [KEY_W-1:0] lo;
    } acc_t;

    function automatic logic is_probe(acc_t a);
        return a.valid && !a.write && a.word && (a.addr == OFF_PROBE);
    endfunction

    function automatic logic is_open_key(acc_t a);
        return a.valid && a.write && !a.word && (a.addr == OFF_KEY) && (a.lo == KEY_OPEN);
    endfunction

    function automatic logic is_close_key(acc_t a);
        return a.valid && a.write && (a.addr == OFF_KEY) && (a.lo == KEY_CLOSE);
    endfunction

    function automatic logic is_commit(acc_t a);
        return a.valid && a.write && (a.addr == OFF_CTRL) && (a.lo == KEY_COMMIT);
    endfunction

endpackage

// File: rtl/ata_unlock_seq.sv
module ata_unlock_seq
    import ata_cfg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  acc_t acc,
    output logic win_open,
    output seq_e seq_st
);

    always_ff @(posedge clk) begin
        if (rst) begin
            win_open <= 1'b0;
            seq_st   <= SEQ_IDLE;
        end else if (acc.valid) begin
            if (!win_open) begin
                unique case (seq_st)
                    SEQ_IDLE: seq_st <= is_probe(acc) ? SEQ_ONE : SEQ_IDLE;
                    SEQ_ONE:  seq_st <= is_probe(acc) ? SEQ_TWO : SEQ_IDLE;
                    SEQ_TWO: begin
                        if (is_probe(acc)) begin
                            seq_st <= SEQ_TWO;
                        end else begin
                            seq_st <= SEQ_IDLE;
                            if (is_open_key(acc)) win_open <= 1'b1;
                        end
                    end
                    default: seq_st <= SEQ_IDLE;
                endcase
            end else begin
                seq_st <= SEQ_IDLE;
                if (is_close_key(acc)) win_open <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/ata_timing_bank.sv
module ata_timing_bank #(
    parameter int NDEV    = 2,
    parameter int TIM_W   = 8,
    parameter logic [TIM_W-1:0] DEF_TIM = '1,
    localparam int SEL_W  = (NDEV > 1) ? $clog2(NDEV) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rd_we,
    input  logic                  wr_we,
    input  logic [SEL_W-1:0]      sel,
    input  logic [TIM_W-1:0]      wdata,
    input  logic                  commit,
    output logic [TIM_W-1:0]      stg_rd,
    output logic [TIM_W-1:0]      stg_wr,
    output logic [NDEV*TIM_W-1:0] cm_rd,
    output logic [NDEV*TIM_W-1:0] cm_wr
);

    logic [TIM_W-1:0] rd_q [NDEV];
    logic [TIM_W-1:0] wr_q [NDEV];

    for (genvar d = 0; d < NDEV; d++) begin : g_dev
        localparam logic [SEL_W-1:0] ME = SEL_W'(d);

        always_ff @(posedge clk) begin
            if (rst) begin
                rd_q[d] <= DEF_TIM;
                wr_q[d] <= DEF_TIM;
            end else begin
                if (rd_we && sel == ME) rd_q[d] <= wdata;
                if (wr_we && sel == ME) wr_q[d] <= wdata;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                cm_rd[d*TIM_W +: TIM_W] <= DEF_TIM;
                cm_wr[d*TIM_W +: TIM_W] <= DEF_TIM;
            end else if (commit) begin
                cm_rd[d*TIM_W +: TIM_W] <= rd_q[d];
                cm_wr[d*TIM_W +: TIM_W] <= wr_q[d];
            end
        end
    end

    always_comb begin
        stg_rd = '0;
        stg_wr = '0;
        for (int d = 0; d < NDEV; d++) begin
            if (sel == SEL_W'(d)) begin
                stg_rd = rd_q[d];
                stg_wr = wr_q[d];
            end
        end
    end

endmodule

// File: rtl/ata_cfg_window.sv
module ata_cfg_window #(
    parameter int DATA_W  = 16,
    parameter int NDEV    = 2,
    parameter int REG_W   = 8,
    parameter logic [REG_W-1:0] DEF_TIM = 8'hFF,
    localparam int SEL_W   = (NDEV > 1) ? $clog2(NDEV) : 1,
    localparam int SETUP_W = REG_W - SEL_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_valid,
    input  logic                  bus_write,
    input  logic                  bus_word,
    input  logic [2:0]            bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic [REG_W-1:0]      strap_in,
    output logic                  tf_valid,
    output logic                  tf_write,
    output logic                  tf_word,
    output logic [2:0]            tf_addr,
    output logic [DATA_W-1:0]     tf_wdata,
    input  logic [DATA_W-1:0]     tf_rdata,
    output logic [NDEV*REG_W-1:0] tim_rd_o,
    output logic [NDEV*REG_W-1:0] tim_wr_o,
    output logic [SETUP_W-1:0]    setup_o
);
    import ata_cfg_pkg::*;

    acc_t acc;
    logic win_open;
    seq_e seq_st;

    assign acc.valid = bus_valid;
    assign acc.write = bus_write;
    assign acc.word  = bus_word;
    assign acc.addr  = bus_addr;
    assign acc.lo    = bus_wdata[KEY_W-1:0];

    ata_unlock_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .acc      (acc),
        .win_open (win_open),
        .seq_st   (seq_st)
    );

    // Window-side decode: only live while the window is open
    logic win_wr;
    logic commit;
    assign win_wr = win_open && bus_valid && bus_write;
    assign commit = win_open && is_commit(acc);

    logic [REG_W-1:0] misc_q;
    logic [REG_W-1:0] ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            misc_q  <= '0;
            ctrl_q  <= '0;
            setup_o <= '0;
        end else begin
            if (win_wr && bus_addr == OFF_MISC) misc_q <= bus_wdata[REG_W-1:0];
            if (win_wr && bus_addr == OFF_CTRL) ctrl_q <= bus_wdata[REG_W-1:0];
            if (commit) setup_o <= misc_q[REG_W-1:SEL_W];
        end
    end

    logic [REG_W-1:0] stg_rd;
    logic [REG_W-1:0] stg_wr;

    ata_timing_bank #(
        .NDEV    (NDEV),
        .TIM_W   (REG_W),
        .DEF_TIM (DEF_TIM)
    ) u_bank (
        .clk    (clk),
        .rst    (rst),
        .rd_we  (win_wr && bus_addr == OFF_RDTIM),
        .wr_we  (win_wr && bus_addr == OFF_WRTIM),
        .sel    (misc_q[SEL_W-1:0]),
        .wdata  (bus_wdata[REG_W-1:0]),
        .commit (commit),
        .stg_rd (stg_rd),
        .stg_wr (stg_wr),
        .cm_rd  (tim_rd_o),
        .cm_wr  (tim_wr_o)
    );

    logic [REG_W-1:0] win_byte;

    always_comb begin
        unique case (bus_addr)
            OFF_RDTIM: win_byte = stg_rd;
            OFF_WRTIM: win_byte = stg_wr;
            OFF_CTRL:  win_byte = ctrl_q;
            OFF_STRAP: win_byte = strap_in;
            OFF_MISC:  win_byte = misc_q;
            default:   win_byte = '0;
        endcase
    end

    assign bus_rdata = win_open ? DATA_W'(win_byte) : tf_rdata;

    assign tf_valid = bus_valid && !win_open;
    assign tf_write = bus_write;
    assign tf_word  = bus_word;
    assign tf_addr  = bus_addr;
    assign tf_wdata = bus_wdata;

endmodule

// File: rtl/ata_cfg_window_chk.sv
module ata_cfg_window_chk #(
    parameter int DATA_W  = 16,
    parameter int NDEV    = 2,
    parameter int REG_W   = 8,
    parameter int SETUP_W = 7
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  bus_valid,
    input logic                  bus_write,
    input logic                  bus_word,
    input logic [2:0]            bus_addr,
    input logic [DATA_W-1:0]     bus_wdata,
    input logic [DATA_W-1:0]     bus_rdata,
    input logic [REG_W-1:0]      strap_in,
    input logic                  tf_valid,
    input logic [2:0]            tf_addr,
    input logic [NDEV*REG_W-1:0] tim_rd_o,
    input logic [NDEV*REG_W-1:0] tim_wr_o,
    input logic [SETUP_W-1:0]    setup_o,
    input logic                  win_open,
    input logic [1:0]            seq_st
);
    import ata_cfg_pkg::*;

    acc_t a;
    assign a = '{valid: bus_valid, write: bus_write, word: bus_word,
                 addr: bus_addr, lo: bus_wdata[KEY_W-1:0]};

    p_forward_r1: assert property (@(posedge clk) disable iff (rst)
        (!win_open && bus_valid) |-> (tf_valid && tf_addr == bus_addr));

    p_open_r2: assert property (@(posedge clk) disable iff (rst)
        (!win_open && seq_st == SEQ_TWO && is_open_key(a)) |=> win_open);

    p_restart_r3: assert property (@(posedge clk) disable iff (rst)
        (!win_open && bus_valid && !is_probe(a)) |=> (seq_st == SEQ_IDLE));

    p_close_r4: assert property (@(posedge clk) disable iff (rst)
        (win_open && is_close_key(a)) |=> !win_open);

    p_hidden_r4: assert property (@(posedge clk) disable iff (rst)
        (win_open && bus_valid) |-> !tf_valid);

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !(win_open && is_commit(a)) |=> ($stable(tim_rd_o) && $stable(tim_wr_o) && $stable(setup_o)));

    p_strap_r8: assert property (@(posedge clk) disable iff (rst)
        (win_open && bus_valid && !bus_write && bus_addr == OFF_STRAP)
        |-> (bus_rdata == DATA_W'(strap_in)));

endmodule

bind ata_cfg_window ata_cfg_window_chk #(
    .DATA_W  (DATA_W),
    .NDEV    (NDEV),
    .REG_W   (REG_W),
    .SETUP_W (SETUP_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_word  (bus_word),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .strap_in  (strap_in),
    .tf_valid  (tf_valid),
    .tf_addr   (tf_addr),
    .tim_rd_o  (tim_rd_o),
    .tim_wr_o  (tim_wr_o),
    .setup_o   (setup_o),
    .win_open  (win_open),
    .seq_st    (seq_st)
);

// File: tb/ata_cfg_window_tb_top.sv
`timescale 1ns/1ps
module ata_cfg_window_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic        bus_word  = 1'b0;
    logic [2:0]  bus_addr  = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  strap_in  = 8'h01;
    logic        tf_valid, tf_write, tf_word;
    logic [2:0]  tf_addr;
    logic [15:0] tf_wdata;
    logic [15:0] tf_rdata;
    logic [15:0] tim_rd_o, tim_wr_o;
    logic [6:0]  setup_o;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    assign tf_rdata = 16'hB000 | {13'd0, tf_addr};

    ata_cfg_window dut_i (
        .clk(clk), .rst(rst),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_word(bus_word),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .strap_in(strap_in),
        .tf_valid(tf_valid), .tf_write(tf_write), .tf_word(tf_word),
        .tf_addr(tf_addr), .tf_wdata(tf_wdata), .tf_rdata(tf_rdata),
        .tim_rd_o(tim_rd_o), .tim_wr_o(tim_wr_o), .setup_o(setup_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic acc(input logic w, input logic wd, input logic [2:0] a, input logic [15:0] d,
                       output logic [15:0] rd, output logic fw);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = w; bus_word = wd; bus_addr = a; bus_wdata = d;
        #2;
        rd = bus_rdata;
        fw = tf_valid;
        @(posedge clk);
        #1;
        bus_valid = 1'b0;
    endtask

    task automatic do_unlock(output logic fw_key);
        logic [15:0] rd;
        logic fw;
        acc(0, 1, 3'd1, 16'h0, rd, fw);
        acc(0, 1, 3'd1, 16'h0, rd, fw);
        acc(1, 0, 3'd2, 16'h0003, rd, fw_key);
    endtask

    task automatic t_reset();
        logic [15:0] rd;
        logic fw;
        check("R9 committed read timing", tim_rd_o, 16'hFFFF);
        check("R9 committed write timing", tim_wr_o, 16'hFFFF);
        check("R9 setup", setup_o, 7'd0);
        acc(0, 0, 3'd6, 16'h0, rd, fw);
        check("R9 locked after reset", fw, 1'b1);
    endtask

    task automatic t_forward();
        logic [15:0] rd;
        logic fw;
        acc(0, 1, 3'd4, 16'h0, rd, fw);
        check("R1 read forwarded", fw, 1'b1);
        check("R1 read data from task file", rd, 16'hB004);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_word = 1'b0; bus_addr = 3'd7; bus_wdata = 16'h5A3C;
        #2;
        check("R1 write fields", {tf_valid, tf_write, tf_word, tf_addr, tf_wdata},
              {1'b1, 1'b1, 1'b0, 3'd7, 16'h5A3C});
        @(posedge clk); #1; bus_valid = 1'b0;
    endtask

    task automatic t_broken();
        logic [15:0] rd;
        logic fw;
        // byte read of the probe offset breaks the chain
        acc(0, 1, 3'd1, 16'h0, rd, fw);
        acc(0, 0, 3'd1, 16'h0, rd, fw);
        acc(0, 1, 3'd1, 16'h0, rd, fw);
        acc(1, 0, 3'd2, 16'h0003, rd, fw);
        acc(0, 0, 3'd0, 16'h0, rd, fw);
        check("R3 byte read restarts", fw, 1'b1);
        // wrong key value
        acc(0, 1, 3'd1, 16'h0, rd, fw);
        acc(0, 1, 3'd1, 16'h0, rd, fw);
        acc(1, 0, 3'd2, 16'h0004, rd, fw);
        acc(0, 0, 3'd0, 16'h0, rd, fw);
        check("R3 wrong key stays locked", fw, 1'b1);
        // other offset in between
        acc(0, 1, 3'd1, 16'h0, rd, fw);
        acc(0, 1, 3'd0, 16'h0, rd, fw);
        acc(0, 1, 3'd1, 16'h0, rd, fw);
        acc(1, 0, 3'd2, 16'h0003, rd, fw);
        acc(0, 0, 3'd0, 16'h0, rd, fw);
        check("R3 other offset restarts", fw, 1'b1);
        // key written as a word
        acc(0, 1, 3'd1, 16'h0, rd, fw);
        acc(0, 1, 3'd1, 16'h0, rd, fw);
        acc(1, 1, 3'd2, 16'h0003, rd, fw);
        acc(0, 0, 3'd0, 16'h0, rd, fw);
        check("R3 word-size key stays locked", fw, 1'b1);
    endtask

    task automatic t_unlock();
        logic [15:0] rd;
        logic fw, fk;
        // three probe reads keep the condition
        acc(0, 1, 3'd1, 16'h0, rd, fw);
        do_unlock(fk);
        check("R2 opening write forwarded", fk, 1'b1);
        acc(0, 0, 3'd6, 16'h0, rd, fw);
        check("R2 window hides task file", fw, 1'b0);
        check("R9 misc reads zero", rd, 16'h0000);
        acc(0, 0, 3'd0, 16'h0, rd, fw);
        check("R9 staged read timing default", rd, 16'h00FF);
        acc(0, 0, 3'd1, 16'h0, rd, fw);
        check("R9 staged write timing default", rd, 16'h00FF);
    endtask

    task automatic t_window();
        logic [15:0] rd;
        logic fw;
        acc(1, 0, 3'd6, 16'h0000, rd, fw);
        acc(1, 0, 3'd0, 16'hAA59, rd, fw);
        acc(1, 0, 3'd1, 16'h0046, rd, fw);
        acc(1, 0, 3'd6, 16'h0001, rd, fw);
        acc(1, 0, 3'd0, 16'h0020, rd, fw);
        acc(1, 0, 3'd1, 16'h0032, rd, fw);
        acc(0, 0, 3'd0, 16'h0, rd, fw);
        check("R5 drive1 read timing", rd, 16'h0020);
        acc(0, 0, 3'd1, 16'h0, rd, fw);
        check("R5 drive1 write timing", rd, 16'h0032);
        acc(1, 0, 3'd6, 16'h0030, rd, fw);
        acc(0, 0, 3'd0, 16'h0, rd, fw);
        check("R5 drive0 read timing low byte", rd, 16'h0059);
        acc(0, 0, 3'd1, 16'h0, rd, fw);
        check("R5 drive0 write timing", rd, 16'h0046);
        acc(0, 0, 3'd6, 16'h0, rd, fw);
        check("R6 misc readback", rd, 16'h0030);
        acc(0, 0, 3'd2, 16'h0, rd, fw);
        check("R5 offset2 reads zero", rd, 16'h0000);
        acc(0, 0, 3'd4, 16'h0, rd, fw);
        check("R5 offset4 reads zero", rd, 16'h0000);
        acc(0, 0, 3'd7, 16'h0, rd, fw);
        check("R5 offset7 reads zero", rd, 16'h0000);
        check("R7 outputs not yet committed", tim_rd_o, 16'hFFFF);
    endtask

    task automatic t_commit();
        logic [15:0] rd;
        logic fw;
        acc(1, 0, 3'd6, 16'h0021, rd, fw);
        acc(1, 0, 3'd3, 16'h0084, rd, fw);
        check("R10 non-commit code holds read timing", tim_rd_o, 16'hFFFF);
        check("R10 non-commit code holds setup", setup_o, 7'd0);
        acc(0, 0, 3'd3, 16'h0, rd, fw);
        check("R10 control readback", rd, 16'h0084);
        acc(1, 0, 3'd3, 16'h0085, rd, fw);
        check("R7 committed read timing", tim_rd_o, 16'h2059);
        check("R7 committed write timing", tim_wr_o, 16'h3246);
        check("R7 R6 committed setup", setup_o, 7'h10);
    endtask

    task automatic t_strap();
        logic [15:0] rd;
        logic fw;
        strap_in = 8'h01;
        acc(0, 0, 3'd5, 16'h0, rd, fw);
        check("R8 strap 25 MHz", rd, 16'h0001);
        acc(1, 0, 3'd5, 16'h00FE, rd, fw);
        acc(0, 0, 3'd5, 16'h0, rd, fw);
        check("R8 strap write ignored", rd, 16'h0001);
        strap_in = 8'h00;
        acc(0, 0, 3'd5, 16'h0, rd, fw);
        check("R8 strap 33 MHz", rd, 16'h0000);
    endtask

    task automatic t_relock();
        logic [15:0] rd;
        logic fw;
        acc(1, 0, 3'd2, 16'h0083, rd, fw);
        check("R4 close write not forwarded", fw, 1'b0);
        acc(0, 1, 3'd3, 16'h0, rd, fw);
        check("R4 next access forwarded", fw, 1'b1);
        check("R4 task file data after close", rd, 16'hB003);
        check("R7 outputs kept after close", tim_wr_o, 16'h3246);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_forward();
        t_broken();
        t_unlock();
        t_window();
        t_commit();
        t_strap();
        t_relock();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule